// File: doc/BRIEF.md
# Tag-Steered FIFO Drain Engine

This block is the receive end of a word-stream DMA path. It empties 32-bit words from a transfer FIFO into memory. Software does not program a destination or a length. The stream describes itself: each block of data is preceded by a four-word header, and the engine decodes that header to learn where the data goes, how many words follow, and whether this block is the last one.

A one-cycle start pulse arms the engine. It then repeats a loop of header, then data, then header again. It stops after a block whose header carries an end marker has been fully written. After the last word it drops its busy flag. It waits a number of cycles that grows with the amount of data moved, then pulses a completion interrupt. The interrupt also clears the transfer-active flag.

Top module: `tagged_fifo_unloader`

## Requirements
- R1: After reset, busy, active, interrupt, FIFO pop and memory write are all low. A start pulse while idle raises both busy and active on the next clock.
- R2: A header is fetched only when no data words of the current block remain, the end marker is clear and the FIFO level is at least 4. The fetch pops exactly four words, one per cycle. A level below 4 leaves the FIFO untouched.
- R3: The destination byte address of a block is bits [23:0] of header word 0. Bits [31:24] of that word do not affect the address.
- R4: The block length in words is header word 1 ANDed with 0xFFFFC. If word 1 exceeds 0xFFFFC, the overrun flag is set. The overrun flag is cleared by start.
- R5: The end marker is set when bit 31 (interrupt request) or bit 30 (top bit of the 3-bit ID in bits [30:28]) of header word 0 is set. ID bits 29 and 28 alone do not end the transfer.
- R6: While words of a block remain, each cycle with a non-zero FIFO level pops one word and writes it to the current address. The address then advances by 4. Nothing is written when the FIFO is empty.
- R7: A header with masked length 0 and no end marker moves no data, and the next header is fetched.
- R8: When no words remain and the end marker is set, busy drops. The completion interrupt is a one-cycle pulse exactly D cycles later, where D = max(1, floor(words moved / 4)). Words moved counts data words only, not header words.
- R9: The cycle after the completion pulse, active is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored unless idle |
| fifo_data_i | input | 32 | Head-of-FIFO word (show-ahead) |
| fifo_level_i | input | 8 | Words currently held in the FIFO |
| fifo_pop_o | output | 1 | Pops the head word at the clock edge |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Byte address of the write |
| mem_data_o | output | 32 | Write data |
| busy_o | output | 1 | Engine is fetching headers or moving data |
| active_o | output | 1 | Transfer in progress until completion |
| overrun_o | output | 1 | A length field was truncated by the mask |
| done_irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The assertions take two things for granted about the FIFO. First, fifo_level_i counts the words actually held. Second, it never drops except through this block's own pops; pushes may arrive at any time. Under those conditions, a header fetch that starts with four words available can always finish. The bench's FIFO model meets both: the model alone adds words between clock edges, and only the engine's pop removes them. Streams are fed both in bursts and one word at a time with idle gaps, so that starvation in the middle of a block is covered.

// File: rtl/ufu_pkg.sv
package ufu_pkg;
   typedef enum logic [2:0] {
      UFU_IDLE,
      UFU_SCAN,
      UFU_HDR,
      UFU_DATA,
      UFU_DONE
   } ufu_state_e;

   localparam int UFU_HDR_WORDS = 4;
   localparam int UFU_IRQ_BIT   = 31;
   localparam int UFU_ENDID_BIT = 30;
endpackage

// File: rtl/ufu_hdr_decode.sv
module ufu_hdr_decode #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 20,
   parameter int ALIGN_LOG2 = 2
) (
   input  logic [DATA_W-1:0] tag_word_i,
   input  logic [DATA_W-1:0] len_word_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  len_o,
   output logic              last_o,
   output logic              over_o
);
   localparam int unsigned MASK_I =
      ((32'd1 << CNT_W) - 32'd1) & ~((32'd1 << ALIGN_LOG2) - 32'd1);
   localparam logic [DATA_W-1:0] LEN_MASK = DATA_W'(MASK_I);

   always_comb begin
      addr_o = tag_word_i[ADDR_W-1:0];
      len_o  = CNT_W'(len_word_i & LEN_MASK);
      last_o = tag_word_i[ufu_pkg::UFU_IRQ_BIT] | tag_word_i[ufu_pkg::UFU_ENDID_BIT];
      over_o = len_word_i > LEN_MASK;
   end
endmodule

// File: rtl/ufu_done_timer.sv
module ufu_done_timer #(
   parameter int MOVED_W  = 24,
   parameter int SHIFT    = 2,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [MOVED_W-1:0] moved_i,
   output logic               irq_o
);
   logic [MOVED_W:0]   scaled;
   logic [MOVED_W-1:0] delay, cnt_q;
   logic               run_q;

   generate
      if (ROUND_UP) begin : g_ceil
         assign scaled = ({1'b0, moved_i} + (MOVED_W+1)'((1 << SHIFT) - 1)) >> SHIFT;
      end else begin : g_floor
         assign scaled = {1'b0, moved_i} >> SHIFT;
      end
   endgenerate

   assign delay = (scaled == '0) ? MOVED_W'(1) : scaled[MOVED_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (load_i) begin
            cnt_q <= delay;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (cnt_q == MOVED_W'(1)) begin
               irq_o <= 1'b1;
               run_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - MOVED_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/tagged_fifo_unloader.sv
module tagged_fifo_unloader #(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 24,
   parameter int CNT_W          = 20,
   parameter int ALIGN_LOG2     = 2,
   parameter int LVL_W          = 8,
   parameter int MOVED_W        = 24,
   parameter int DELAY_SHIFT    = 2,
   parameter bit DELAY_ROUND_UP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] fifo_data_i,
   input  logic [LVL_W-1:0]  fifo_level_i,
   output logic              fifo_pop_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              busy_o,
   output logic              active_o,
   output logic              overrun_o,
   output logic              done_irq_o
);
   import ufu_pkg::*;

   localparam int BYTES   = DATA_W / 8;
   localparam int HIDX_W  = $clog2(UFU_HDR_WORDS);

   generate
      if (ADDR_W > DATA_W) begin : g_chk_addr
         $error("ADDR_W must not exceed DATA_W");
      end
      if (CNT_W >= 32 || CNT_W <= ALIGN_LOG2) begin : g_chk_cnt
         $error("CNT_W must lie between ALIGN_LOG2 and 31");
      end
      if ((1 << LVL_W) <= UFU_HDR_WORDS) begin : g_chk_lvl
         $error("LVL_W too small to express a full header");
      end
      if (DATA_W % 8 != 0 || DATA_W < 32) begin : g_chk_data
         $error("DATA_W must be a byte multiple of at least 32");
      end
   endgenerate

   ufu_state_e         st_q;
   logic [HIDX_W-1:0]  hidx_q;
   logic [DATA_W-1:0]  tag_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [CNT_W-1:0]   rem_q;
   logic [MOVED_W-1:0] moved_q;
   logic               last_q, busy_q, active_q, over_q;

   logic [ADDR_W-1:0]  dec_addr;
   logic [CNT_W-1:0]   dec_len;
   logic               dec_last, dec_over;
   logic               has_word, timer_load, timer_irq;

   ufu_hdr_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ALIGN_LOG2(ALIGN_LOG2)
   ) dec_i (
      .tag_word_i(tag_q), .len_word_i(fifo_data_i),
      .addr_o(dec_addr), .len_o(dec_len), .last_o(dec_last), .over_o(dec_over)
   );

   assign timer_load = (st_q == UFU_SCAN) && last_q;

   ufu_done_timer #(
      .MOVED_W(MOVED_W), .SHIFT(DELAY_SHIFT), .ROUND_UP(DELAY_ROUND_UP)
   ) tmr_i (
      .clk(clk), .rst_n(rst_n), .load_i(timer_load), .moved_i(moved_q), .irq_o(timer_irq)
   );

   assign has_word   = fifo_level_i != '0;
   assign mem_we_o   = (st_q == UFU_DATA) && has_word;
   assign fifo_pop_o = (st_q == UFU_HDR) || mem_we_o;
   assign mem_addr_o = addr_q;
   assign mem_data_o = fifo_data_i;
   assign busy_o     = busy_q;
   assign active_o   = active_q;
   assign overrun_o  = over_q;
   assign done_irq_o = timer_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= UFU_IDLE;
         hidx_q   <= '0;
         tag_q    <= '0;
         addr_q   <= '0;
         rem_q    <= '0;
         moved_q  <= '0;
         last_q   <= 1'b0;
         busy_q   <= 1'b0;
         active_q <= 1'b0;
         over_q   <= 1'b0;
      end else begin
         unique case (st_q)
            UFU_IDLE: if (start_i) begin
               busy_q   <= 1'b1;
               active_q <= 1'b1;
               over_q   <= 1'b0;
               moved_q  <= '0;
               last_q   <= 1'b0;
               rem_q    <= '0;
               st_q     <= UFU_SCAN;
            end
            UFU_SCAN: begin
               if (last_q) begin
                  busy_q <= 1'b0;
                  last_q <= 1'b0;
                  addr_q <= '0;
                  tag_q  <= '0;
                  st_q   <= UFU_DONE;
               end else if (fifo_level_i >= LVL_W'(UFU_HDR_WORDS)) begin
                  hidx_q <= '0;
                  st_q   <= UFU_HDR;
               end
            end
            UFU_HDR: begin
               hidx_q <= hidx_q + HIDX_W'(1);
               if (hidx_q == HIDX_W'(0)) tag_q <= fifo_data_i;
               if (hidx_q == HIDX_W'(1)) begin
                  addr_q <= dec_addr;
                  rem_q  <= dec_len;
                  last_q <= dec_last;
                  if (dec_over) over_q <= 1'b1;
               end
               if (hidx_q == HIDX_W'(UFU_HDR_WORDS - 1))
                  st_q <= (rem_q == '0) ? UFU_SCAN : UFU_DATA;
            end
            UFU_DATA: if (has_word) begin
               addr_q <= addr_q + ADDR_W'(BYTES);
               rem_q  <= rem_q - CNT_W'(1);
               if (moved_q != '1) moved_q <= moved_q + MOVED_W'(1);
               if (rem_q == CNT_W'(1)) st_q <= UFU_SCAN;
            end
            UFU_DONE: if (timer_irq) begin
               active_q <= 1'b0;
               st_q     <= UFU_IDLE;
            end
            default: st_q <= UFU_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tagged_fifo_unloader_chk.sv
module tagged_fifo_unloader_chk #(
   parameter int ADDR_W = 24,
   parameter int LVL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_W-1:0]  fifo_level_i,
   input logic              fifo_pop_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              busy_o,
   input logic              active_o,
   input logic              done_irq_o
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_we_o && !fifo_pop_o));

   assert_hdr_needs_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop_o && !mem_we_o && !$past(fifo_pop_o)) |-> (fifo_level_i >= LVL_W'(4)));

   assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop_o |-> (fifo_level_i != '0));

   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq_o |=> !done_irq_o);

   assert_irq_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq_o |-> (!busy_o && active_o));

   assert_irq_clears_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq_o |=> !active_o);
endmodule

bind tagged_fifo_unloader tagged_fifo_unloader_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .fifo_level_i(fifo_level_i), .fifo_pop_o(fifo_pop_o),
   .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o), .active_o(active_o),
   .done_irq_o(done_irq_o)
);

// File: tb/tagged_fifo_unloader_tb_top.sv
module tagged_fifo_unloader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] fifo_data;
   logic [7:0]  fifo_level;
   logic        pop, we, busy, active, over, irq;
   logic [23:0] maddr;
   logic [31:0] mdata;

   int n_run = 0, n_fail = 0;
   logic [31:0] fq [0:255];
   int wp = 0, rp = 0;
   logic [23:0] log_a [0:63];
   logic [31:0] log_d [0:63];
   int nwr = 0, npop = 0, bad_we = 0;

   always #10 clk = ~clk;

   assign fifo_level = 8'(wp - rp);
   assign fifo_data  = fq[rp[7:0]];

   tagged_fifo_unloader dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .fifo_data_i(fifo_data),
      .fifo_level_i(fifo_level), .fifo_pop_o(pop), .mem_we_o(we), .mem_addr_o(maddr),
      .mem_data_o(mdata), .busy_o(busy), .active_o(active), .overrun_o(over),
      .done_irq_o(irq)
   );

   always @(posedge clk) begin
      if (pop) begin
         rp <= rp + 1;
         npop = npop + 1;
      end
      if (we) begin
         if (fifo_level == 8'd0) bad_we = bad_we + 1;
         if (nwr < 64) begin
            log_a[nwr] = maddr;
            log_d[nwr] = mdata;
         end
         nwr = nwr + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] w);
      fq[wp[7:0]] = w;
      wp = wp + 1;
   endtask

   task automatic push_data(input logic [15:0] base, input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         push({base, 16'(i)});
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic go();
      @(negedge clk);
      nwr = 0; npop = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && active, "R1", "busy/active after start", {busy, active}, 2'b11);
      chk(!over, "R4", "overrun cleared by start", over, 0);
   endtask

   task automatic wait_done(input int exp_d, input string tag);
      int k;
      while (busy) @(negedge clk);
      k = 0;
      while (!irq) begin
         @(negedge clk);
         k++;
      end
      chk(k == exp_d, "R8", {tag, " completion delay"}, k, exp_d);
      @(negedge clk);
      chk(!irq, "R8", {tag, " irq one cycle"}, irq, 0);
      chk(!active, "R9", {tag, " active cleared"}, active, 0);
   endtask

   task automatic chk_block(input int first, input int n, input logic [23:0] a0,
                            input logic [15:0] base, input string req);
      for (int i = 0; i < n; i++) begin
         chk(log_a[first+i] == a0 + 24'(4*i), req, "write address", log_a[first+i], a0 + 24'(4*i));
         chk(log_d[first+i] == {base, 16'(i)}, "R6", "write data", log_d[first+i], {base, 16'(i)});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !active && !irq && !pop && !we, "R1", "reset state",
          {busy, active, irq, pop, we}, 0);

      // S1: single block, end via IRQ bit, 8 words
      go();
      push(32'h8012_3450); push(32'd8); push(32'h0); push(32'h0);
      push_data(16'hA001, 8, 0);
      wait_done(2, "S1");
      chk(nwr == 8, "R6", "S1 write count", nwr, 8);
      chk_block(0, 8, 24'h12_3450, 16'hA001, "R3");
      chk(!over, "R4", "S1 no overrun", over, 0);

      // S2: high tag bits ignored in address, count 7 -> 4, then oversize zero-length end block
      go();
      push(32'h0F00_0100); push(32'd7); push(32'h1); push(32'h2);
      push_data(16'hB002, 4, 0);
      push(32'hC000_0200); push(32'h0010_0003); push(32'h0); push(32'h0);
      wait_done(1, "S2");
      chk(nwr == 4, "R4", "S2 masked length", nwr, 4);
      chk_block(0, 4, 24'h00_0100, 16'hB002, "R3");
      chk(over, "R4", "S2 overrun flag", over, 1);
      chk(fifo_level == 0, "R2", "S2 all consumed", fifo_level, 0);

      // S3: ID=3 no end, skipped zero-length header, ID bit2 end, starved feed
      go();
      push(32'h3000_0300); push(32'd4); push(32'h0); push(32'h0);
      push_data(16'hC003, 4, 3);
      push(32'h0000_0000); push(32'd3); push(32'h0); push(32'h0);
      push(32'h4000_0400); push(32'd4); push(32'h0); push(32'h0);
      push_data(16'hC004, 4, 3);
      wait_done(2, "S3");
      chk(nwr == 8, "R7", "S3 write count with skip", nwr, 8);
      chk_block(0, 4, 24'h00_0300, 16'hC003, "R5");
      chk_block(4, 4, 24'h00_0400, 16'hC004, "R7");
      chk(npop == 20, "R2", "S3 pops incl headers", npop, 20);
      chk(bad_we == 0, "R6", "no write on empty fifo", bad_we, 0);

      // S4: header held back until four words present
      go();
      push(32'h8000_0800); push(32'd12); push(32'h0);
      repeat (10) @(negedge clk);
      chk(npop == 0, "R2", "S4 no pop below four", npop, 0);
      chk(fifo_level == 3, "R2", "S4 level kept", fifo_level, 3);
      push(32'h0);
      push_data(16'hD004, 12, 0);
      wait_done(3, "S4");
      chk(nwr == 12, "R6", "S4 write count", nwr, 12);
      chk_block(0, 12, 24'h00_0800, 16'hD004, "R3");

      // S5: length sweep, delay = n/4
      for (int k = 1; k <= 12; k++) begin
         go();
         push(32'h8000_0000 | 32'(k * 32'h1000)); push(32'(4*k)); push(32'h0); push(32'h0);
         push_data(16'(16'hE000 + k), 4*k, 0);
         wait_done(k, "S5");
         chk(nwr == 4*k, "R4", "S5 write count", nwr, 4*k);
         chk_block(0, 4*k, 24'(k * 32'h1000), 16'(16'hE000 + k), "R6");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule